// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block moves single bytes out of a program memory organised as 16-bit words and into an 8-bit data latch. Software sets up a 22-bit byte pointer through a small register port made of three byte-wide pointer registers. It then issues a table-read command with a 2-bit mode. The mode chooses whether the pointer stays put, steps forward after the read, steps back after the read, or steps forward before the read.

Pointer bits 20:0 form a byte address. Bits 20:1 become the word address that is presented to memory, and bit 0 chooses which half of the returned word goes into the latch. Bit 21 steers the access to a separate configuration-space read port instead of program memory. Automatic pointer steps never change bit 21.

Each read takes a fixed four cycles: accept, memory access, capture, and a one-cycle done strobe. While a read is in flight the block ignores further commands and holds back software pointer writes until the done cycle.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the pointer reads back as 0x000000, the latch reads 0x00, and `done` and `busy` are low.
- R2: Register select 2 (upper) stores only the low 6 bits of a write; its bits 7:6 always read back as zero. Select 0 is the low byte, select 1 the high byte, and select 3 reads the latch and ignores writes.
- R3: Mode 0 reads the byte at the pointer and leaves the pointer unchanged.
- R4: Mode 1 reads the byte at the pointer, then adds one to the pointer.
- R5: Mode 2 reads the byte at the pointer, then subtracts one from the pointer.
- R6: Mode 3 adds one to the pointer first, then reads the byte at the new pointer value.
- R7: Pointer steps act on bits 20:0 only and wrap within 21 bits. Bit 21 keeps its value.
- R8: With pointer bit 0 set the latch receives bits 15:8 of the memory word; with it clear the latch receives bits 7:0.
- R9: Pointer bit 21 clear enables only the program-memory port and bit 21 set enables only the configuration port. Both ports carry pointer bits 20:1 as the word address, and the two enables are never high together.
- R10: For a command accepted at clock edge k, the chosen read enable is high for the one cycle after k. The memory returns its word one edge later, the latch updates at edge k+2, and `done` is high for exactly the one cycle after k+2. `busy` is high from k until k+3.
- R11: A command presented while `busy` is high has no effect on the pointer, the latch or the memory ports.
- R12: A pointer-register write presented while `busy` is high, or in the same cycle as an accepted command, has no visible effect until the done cycle. It takes effect at the edge that ends the done cycle and overrides the automatic step. A write made during the done cycle itself takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 low, 1 high, 2 upper, 3 latch |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| cmd_valid | input | 1 | Table-read command request |
| cmd_mode | input | 2 | Pointer mode: 0 none, 1 post-increment, 2 post-decrement, 3 pre-increment |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle strobe: the latch holds the new byte |
| latch_q | output | 8 | Data latch |
| pm_rd_en | output | 1 | Program-memory read enable |
| pm_addr | output | 20 | Program-memory word address |
| pm_rdata | input | 16 | Program-memory word, valid one cycle after the enable |
| cfg_rd_en | output | 1 | Configuration-space read enable |
| cfg_addr | output | 20 | Configuration-space word address |
| cfg_rdata | input | 16 | Configuration word, valid one cycle after the enable |

## Verification
The assertions check the invariants that hold on every cycle. The two read enables are never high together, and a read enable follows every accepted command. `done` is a single-cycle pulse that only occurs while busy, the latch changes only where `done` shows it, and the upper register's top bits always read as zero. The per-mode pointer arithmetic, the 21-bit wrap with bit 21 held, the byte-half choice, and the held-off software writes depend on values chosen by software. Only the bench's scenarios can show these, comparing the design against its reference model on every cycle of each read.

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int PTR_W  = 22,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_sel,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_mode,
  output logic                  busy,
  output logic                  done,
  output logic [BYTE_W-1:0]     latch_q,
  output logic                  pm_rd_en,
  output logic [PTR_W-3:0]      pm_addr,
  input  logic [2*BYTE_W-1:0]   pm_rdata,
  output logic                  cfg_rd_en,
  output logic [PTR_W-3:0]      cfg_addr,
  input  logic [2*BYTE_W-1:0]   cfg_rdata
);
  localparam int LOW_W = PTR_W - 1;
  localparam int UP_LO = 2 * BYTE_W;
  localparam int UP_W  = PTR_W - UP_LO;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CAPT, S_DONE} state_t;
  state_t state;

  logic [PTR_W-1:0]  ptr, raddr;
  logic [2:0]        pend_v;
  logic [BYTE_W-1:0] pend_d [3];

  logic [PTR_W-1:0] ptr_up, ptr_dn;
  assign ptr_up = {ptr[PTR_W-1], ptr[LOW_W-1:0] + 1'b1};
  assign ptr_dn = {ptr[PTR_W-1], ptr[LOW_W-1:0] - 1'b1};

  logic accept, defer, wr_ok;
  assign accept = (state == S_IDLE) && cmd_valid;
  assign defer  = accept || (state == S_ISSUE) || (state == S_CAPT);
  assign wr_ok  = reg_wr && (reg_sel != 2'd3);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);

  assign pm_addr   = raddr[LOW_W-1:1];
  assign cfg_addr  = raddr[LOW_W-1:1];
  assign pm_rd_en  = (state == S_ISSUE) && !raddr[PTR_W-1];
  assign cfg_rd_en = (state == S_ISSUE) &&  raddr[PTR_W-1];

  logic [2*BYTE_W-1:0] word;
  assign word = raddr[PTR_W-1] ? cfg_rdata : pm_rdata;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = ptr[BYTE_W-1:0];
      2'd1:    reg_rdata = ptr[UP_LO-1:BYTE_W];
      2'd2:    reg_rdata = {{(BYTE_W-UP_W){1'b0}}, ptr[PTR_W-1:UP_LO]};
      default: reg_rdata = latch_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      raddr   <= '0;
      latch_q <= '0;
      pend_v  <= '0;
      for (int i = 0; i < 3; i++) pend_d[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          raddr <= (cmd_mode == 2'd3) ? ptr_up : ptr;
          case (cmd_mode)
            2'd1, 2'd3: ptr <= ptr_up;
            2'd2:       ptr <= ptr_dn;
            default:    ;
          endcase
          state <= S_ISSUE;
        end
        S_ISSUE: state <= S_CAPT;
        S_CAPT: begin
          latch_q <= raddr[0] ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
          state   <= S_DONE;
        end
        default: begin
          if (pend_v[0]) ptr[BYTE_W-1:0]      <= pend_d[0];
          if (pend_v[1]) ptr[UP_LO-1:BYTE_W]  <= pend_d[1];
          if (pend_v[2]) ptr[PTR_W-1:UP_LO]   <= pend_d[2][UP_W-1:0];
          pend_v <= '0;
          state  <= S_IDLE;
        end
      endcase
      if (wr_ok) begin
        if (defer) begin
          pend_v[reg_sel] <= 1'b1;
          pend_d[reg_sel] <= reg_wdata;
        end else begin
          case (reg_sel)
            2'd0:    ptr[BYTE_W-1:0]     <= reg_wdata;
            2'd1:    ptr[UP_LO-1:BYTE_W] <= reg_wdata;
            default: ptr[PTR_W-1:UP_LO]  <= reg_wdata[UP_W-1:0];
          endcase
        end
      end
    end
  end
endmodule

module tblrd_unit_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              pm_rd_en,
  input logic              cfg_rd_en,
  input logic [BYTE_W-1:0] latch_q,
  input logic [1:0]        reg_sel,
  input logic [BYTE_W-1:0] reg_rdata
);
  p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_rd_en && cfg_rd_en));
  p_rden_follows_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (pm_rd_en || cfg_rd_en));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_latch_only_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> done);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata[BYTE_W-1:BYTE_W-2] == 2'b00));
endmodule

bind tblrd_unit tblrd_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .pm_rd_en(pm_rd_en), .cfg_rd_en(cfg_rd_en), .latch_q(latch_q),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/tblrd_unit_bench.sv
module tblrd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        busy, done, pm_rd_en, cfg_rd_en;
  logic [7:0]  latch_q;
  logic [19:0] pm_addr, cfg_addr;
  logic [15:0] pm_rdata = 16'd0, cfg_rdata = 16'd0;

  int checks = 0;
  int fails  = 0;
  logic [21:0] m_ptr = '0;

  always #10 clk = ~clk;

  tblrd_unit u_tblrd_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_mode(cmd_mode), .busy(busy), .done(done), .latch_q(latch_q),
    .pm_rd_en(pm_rd_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [15:0] pm_word(logic [19:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + a[19:12]};
  endfunction
  function automatic logic [15:0] cfg_word(logic [19:0] a);
    return {~a[7:0], a[15:8] ^ 8'h5A};
  endfunction
  function automatic logic [21:0] step(logic [21:0] p, int d);
    logic [20:0] lo;
    lo = p[20:0] + 21'(d);
    return {p[21], lo};
  endfunction

  always @(posedge clk) begin
    if (pm_rd_en)  pm_rdata  <= pm_word(pm_addr);
    if (cfg_rd_en) cfg_rdata <= cfg_word(cfg_addr);
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic read_ptr(output logic [21:0] p);
    logic [7:0] b0, b1, b2;
    reg_sel = 2'd0; #1 b0 = reg_rdata;
    reg_sel = 2'd1; #1 b1 = reg_rdata;
    reg_sel = 2'd2; #1 b2 = reg_rdata;
    check(b2[7:6] == 2'b00, "R2", "upper top bits", b2, b2 & 8'h3F);
    p = {b2[5:0], b1, b0};
  endtask

  task automatic chk_ptr(string req, logic [21:0] exp);
    logic [21:0] p;
    read_ptr(p);
    check(p == exp, req, "pointer", p, exp);
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ptr(logic [21:0] p);
    wr_reg(2'd2, {2'b00, p[21:16]});
    wr_reg(2'd1, p[15:8]);
    wr_reg(2'd0, p[7:0]);
    m_ptr = p;
  endtask

  task automatic do_read(string req, logic [1:0] mode, bit extra_cmd, bit extra_wr,
                         logic [7:0] wdat);
    logic [21:0] a, seen;
    logic [15:0] w;
    logic [7:0]  eb;
    a = (mode == 2'd3) ? step(m_ptr, 1) : m_ptr;
    w = a[21] ? cfg_word(a[20:1]) : pm_word(a[20:1]);
    eb = a[0] ? w[15:8] : w[7:0];
    case (mode)
      2'd1, 2'd3: m_ptr = step(m_ptr, 1);
      2'd2:       m_ptr = step(m_ptr, -1);
      default:    ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = mode;
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy after accept", busy, 1);
    check(pm_rd_en == !a[21] && cfg_rd_en == a[21], "R9", "port enables",
          {pm_rd_en, cfg_rd_en}, {!a[21], a[21]});
    check((a[21] ? cfg_addr : pm_addr) == a[20:1], "R9", "word address",
          a[21] ? cfg_addr : pm_addr, a[20:1]);
    check(done == 1'b0, "R10", "done early", done, 0);
    cmd_valid = extra_cmd;
    cmd_mode  = 2'd1;
    if (extra_wr) begin reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = wdat; end
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr = 1'b0;
    check(!pm_rd_en && !cfg_rd_en, "R10", "enable one cycle", {pm_rd_en, cfg_rd_en}, 0);
    check(done == 1'b0, "R10", "done in capture", done, 0);
    @(negedge clk);
    check(done == 1'b1, "R10", "done strobe", done, 1);
    check(latch_q == eb, req, "latch byte", latch_q, eb);
    if (extra_wr) begin
      read_ptr(seen);
      check(seen == m_ptr, "R12", "write held off", seen, m_ptr);
    end
    @(negedge clk);
    if (extra_wr) m_ptr[7:0] = wdat;
    check(done == 1'b0 && busy == 1'b0, "R10", "done/busy cleared", {done, busy}, 0);
    check(latch_q == eb, extra_cmd ? "R11" : req, "latch held", latch_q, eb);
    chk_ptr(extra_cmd ? "R11" : (extra_wr ? "R12" : req), m_ptr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ptr("R1", 22'h0);
    reg_sel = 2'd3; #1;
    check(reg_rdata == 8'h00, "R1", "latch reset", reg_rdata, 0);
    check(done == 1'b0 && busy == 1'b0, "R1", "done/busy reset", {done, busy}, 0);

    wr_reg(2'd2, 8'hFF);
    reg_sel = 2'd2; #1;
    check(reg_rdata == 8'h3F, "R2", "upper write masked", reg_rdata, 8'h3F);
    wr_reg(2'd3, 8'hAA);
    reg_sel = 2'd3; #1;
    check(reg_rdata == 8'h00, "R2", "latch ignores write", reg_rdata, 0);

    set_ptr(22'h001235);
    do_read("R3", 2'd0, 1'b0, 1'b0, 8'h00);
    do_read("R4", 2'd1, 1'b0, 1'b0, 8'h00);
    do_read("R8", 2'd1, 1'b0, 1'b0, 8'h00);
    do_read("R5", 2'd2, 1'b0, 1'b0, 8'h00);
    do_read("R6", 2'd3, 1'b0, 1'b0, 8'h00);
    reg_sel = 2'd3; #1;
    check(reg_rdata == latch_q, "R2", "latch readback", reg_rdata, latch_q);

    set_ptr(22'h1FFFFF);
    do_read("R7", 2'd1, 1'b0, 1'b0, 8'h00);
    set_ptr(22'h3FFFFF);
    do_read("R7", 2'd3, 1'b0, 1'b0, 8'h00);
    set_ptr(22'h200000);
    do_read("R7", 2'd2, 1'b0, 1'b0, 8'h00);
    set_ptr(22'h2ABCD1);
    do_read("R9", 2'd0, 1'b0, 1'b0, 8'h00);

    set_ptr(22'h004400);
    do_read("R11", 2'd0, 1'b1, 1'b0, 8'h00);
    do_read("R12", 2'd1, 1'b0, 1'b1, 8'h77);
    do_read("R8", 2'd0, 1'b0, 1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule